// File: doc/BRIEF.md
# PHY Function and Interface Control Registers

This block is the transceiver-side register file that a link controller programs over a small register bus. It holds two 8-bit control registers: function control and interface control. Each register has three addresses. The first replaces the whole value, the second ORs the write data in, and the third clears every bit where the write data is 1. A read at any of the three addresses returns the register's current value. The block drives the function-control fields straight out to the transceiver datapath: operating mode, termination select and speed select.

Two function-control bits are cleared by hardware rather than by software. Bit 5 is a self-clearing transceiver reset. Once it is set, the block raises the bus-direction output and pulses a core reset for a fixed number of cycles. It then drops the direction output, clears bit 5, and one cycle later pulses a status-update request to the link. Bit 6 is an active-low suspend. The link ends suspend by raising its stop signal, and the block then restores bit 6 to the powered state.

Top module: `phy_ctrl_regs`

## Requirements
- R1: After the synchronous reset, function control reads 41h, interface control reads 00h, and dir, core_rst and rxcmd_req are low.
- R2: Function control is read at addresses 04h, 05h and 06h. A write to 04h replaces the value, a write to 05h ORs the data in, and a write to 06h clears the bits where the data is 1.
- R3: Interface control is read at 07h, 08h and 09h, with replace at 07h, OR at 08h and bit-clear at 09h. All 8 of its bits are writable.
- R4: reg_rdata is registered. It shows the value addressed in the previous cycle, as that value stood before that cycle's write. Any address outside 04h–09h reads 0, and a write to such an address changes nothing.
- R5: Function control bit 7 is reserved. It always reads 0 and ignores writes through every alias.
- R6: When function control bit 5 (reset) becomes 1, dir and core_rst rise one cycle later. core_rst stays high for exactly RST_CYCLES cycles and dir stays high over the same cycles. Both fall on the same edge, and bit 5 reads 0 from that edge on.
- R7: rxcmd_req is high for exactly one cycle, the cycle after dir falls at the end of a reset sequence.
- R8: While dir is high, register writes are ignored for both registers at all aliases.
- R9: When stp is high at a clock edge and function control bit 6 (suspend_n) is 0, bit 6 becomes 1 at that edge. When bit 6 is already 1, stp has no effect.
- R10: When a wake from stp and a link write to function control fall in the same cycle, bit 6 ends up 1 and all other bits take the write result.
- R11: op_mode shows function control bits 4:3, term_sel shows bit 2, xcvr_sel shows bits 1:0, suspend_n shows bit 6, and intf_reg shows the interface control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Registered read data |
| stp | input | 1 | Link stop signal, wakes from suspend |
| dir | output | 1 | Bus direction, high while the transceiver reset runs |
| core_rst | output | 1 | Digital core reset pulse |
| rxcmd_req | output | 1 | One-cycle status update request |
| suspend_n | output | 1 | Function control bit 6, 0 means low power |
| op_mode | output | 2 | Function control bits 4:3 |
| term_sel | output | 1 | Function control bit 2 |
| xcvr_sel | output | 2 | Function control bits 1:0 |
| intf_reg | output | 8 | Interface control register value |

## Verification
A link write to function control and an stp wake can land on the same clock edge, and the write result and the hardware set of bit 6 must then merge correctly. A directed case first clears bit 6, then issues a plain write that carries bit 6 as 0 in the same cycle that stp is high. It expects bit 6 to be 1 and every other bit to equal the written data. The random phase drives writes and stp independently each cycle, so both orders and their overlap recur. A bench model is updated in the same order, write result first and then the wake, and each resulting value is compared with it.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;

  localparam int REG_W   = 8;
  localparam int ALIASES = 3;

  // Alias offset from a register's base address: write, set, clear.
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2
  } alias_op_e;

  // Function control bit positions (decoded by the transceiver datapath).
  localparam int FC_RESET   = 5;
  localparam int FC_SUSP_N  = 6;
  localparam int FC_RSVD    = 7;

  function automatic logic [REG_W-1:0] apply_alias(
    input alias_op_e        op,
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] data
  );
    case (op)
      OP_SET:   return cur | data;
      OP_CLEAR: return cur & ~data;
      default:  return data;
    endcase
  endfunction

endpackage

// File: rtl/ctrl_alias_decode.sv
module ctrl_alias_decode
  import phy_ctrl_pkg::*;
#(
  parameter int                        ADDR_W = 6,
  parameter int                        NREG   = 2,
  parameter logic [NREG*ADDR_W-1:0]    BASES  = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit,
  output alias_op_e         op [NREG]
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] BASE = BASES[i*ADDR_W +: ADDR_W];
    logic [ADDR_W-1:0] offset;

    always_comb begin
      offset = addr - BASE;
      hit[i] = (addr >= BASE) && (offset < ADDR_W'(ALIASES));
      op[i]  = alias_op_e'(offset[1:0]);
    end
  end

endmodule

// File: rtl/ctrl_alias_reg.sv
module ctrl_alias_reg
  import phy_ctrl_pkg::*;
#(
  parameter logic [REG_W-1:0] RESET_VAL = '0,
  parameter logic [REG_W-1:0] WMASK     = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  alias_op_e        op,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] hw_set,
  input  logic [REG_W-1:0] hw_clr,
  output logic [REG_W-1:0] q
);

  logic [REG_W-1:0] sw_next;
  logic [REG_W-1:0] merged;

  always_comb begin
    sw_next = q;
    if (wr_en)
      sw_next = (apply_alias(op, q, wdata) & WMASK) | (RESET_VAL & ~WMASK);
    merged = (sw_next | (hw_set & WMASK)) & ~hw_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= merged;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && hw_set == '0 && hw_clr == '0) |=> $stable(q)); // R8

endmodule

// File: rtl/ctrl_rst_seq.sv
module ctrl_rst_seq #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_req,
  output logic dir,
  output logic core_rst,
  output logic rst_done,
  output logic rxcmd_req
);

  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_RESET, S_NOTIFY} seq_state_e;

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;

  assign rst_done = (state == S_RESET) && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      dir       <= 1'b0;
      core_rst  <= 1'b0;
      rxcmd_req <= 1'b0;
    end else begin
      rxcmd_req <= 1'b0;
      case (state)
        S_IDLE: if (rst_req) begin
          state    <= S_RESET;
          cnt      <= '0;
          dir      <= 1'b1;
          core_rst <= 1'b1;
        end
        S_RESET: begin
          if (cnt == LAST) begin
            state    <= S_NOTIFY;
            dir      <= 1'b0;
            core_rst <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_NOTIFY: begin
          state     <= S_IDLE;
          rxcmd_req <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_CORE_RST_UNDER_DIR: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> dir); // R6
  AST_RXCMD_AFTER_DIR: assert property (@(posedge clk) disable iff (rst)
    $fell(dir) |=> rxcmd_req); // R7
  AST_RXCMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rxcmd_req |=> !rxcmd_req); // R7

endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
  import phy_ctrl_pkg::*;
#(
  parameter int              ADDR_W     = 6,
  parameter int              RST_CYCLES = 16,
  parameter logic [ADDR_W-1:0] FUNC_BASE = ADDR_W'(4),
  parameter logic [ADDR_W-1:0] INTF_BASE = ADDR_W'(7)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_we,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              stp,
  output logic              dir,
  output logic              core_rst,
  output logic              rxcmd_req,
  output logic              suspend_n,
  output logic [1:0]        op_mode,
  output logic              term_sel,
  output logic [1:0]        xcvr_sel,
  output logic [REG_W-1:0]  intf_reg
);

  localparam int NREG = 2;
  localparam int IDX_FUNC = 0;
  localparam int IDX_INTF = 1;
  localparam logic [NREG*ADDR_W-1:0] BASES = {INTF_BASE, FUNC_BASE};
  localparam logic [REG_W-1:0] FUNC_RST_VAL = 8'h41;
  localparam logic [REG_W-1:0] FUNC_WMASK   = ~(REG_W'(1) << FC_RSVD);
  localparam logic [REG_W-1:0] INTF_WMASK   = '1;
  localparam logic [REG_W-1:0] BIT_SUSP     = REG_W'(1) << FC_SUSP_N;
  localparam logic [REG_W-1:0] BIT_RESET    = REG_W'(1) << FC_RESET;

  logic [NREG-1:0]  hit;
  alias_op_e        op [NREG];
  logic [REG_W-1:0] func_q;
  logic [REG_W-1:0] intf_q;
  logic             wr_ok;
  logic             wake;
  logic             rst_done;

  assign wr_ok = reg_we & ~dir;
  assign wake  = stp & ~func_q[FC_SUSP_N];

  ctrl_alias_decode #(
    .ADDR_W (ADDR_W),
    .NREG   (NREG),
    .BASES  (BASES)
  ) u_decode (
    .addr (reg_addr),
    .hit  (hit),
    .op   (op)
  );

  ctrl_alias_reg #(
    .RESET_VAL (FUNC_RST_VAL),
    .WMASK     (FUNC_WMASK)
  ) u_func (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_ok & hit[IDX_FUNC]),
    .op     (op[IDX_FUNC]),
    .wdata  (reg_wdata),
    .hw_set (wake ? BIT_SUSP : '0),
    .hw_clr (rst_done ? BIT_RESET : '0),
    .q      (func_q)
  );

  ctrl_alias_reg #(
    .RESET_VAL ('0),
    .WMASK     (INTF_WMASK)
  ) u_intf (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_ok & hit[IDX_INTF]),
    .op     (op[IDX_INTF]),
    .wdata  (reg_wdata),
    .hw_set ('0),
    .hw_clr ('0),
    .q      (intf_q)
  );

  ctrl_rst_seq #(
    .RST_CYCLES (RST_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .rst_req   (func_q[FC_RESET]),
    .dir       (dir),
    .core_rst  (core_rst),
    .rst_done  (rst_done),
    .rxcmd_req (rxcmd_req)
  );

  always_ff @(posedge clk) begin
    if (rst)                reg_rdata <= '0;
    else if (hit[IDX_FUNC]) reg_rdata <= func_q;
    else if (hit[IDX_INTF]) reg_rdata <= intf_q;
    else                    reg_rdata <= '0;
  end

  assign suspend_n = func_q[FC_SUSP_N];
  assign op_mode   = func_q[4:3];
  assign term_sel  = func_q[2];
  assign xcvr_sel  = func_q[1:0];
  assign intf_reg  = intf_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !func_q[FC_RSVD]); // R5
  AST_DIR_BLOCKS_INTF: assert property (@(posedge clk) disable iff (rst)
    dir |=> $stable(intf_q)); // R8
  AST_DIR_BLOCKS_FUNC: assert property (@(posedge clk) disable iff (rst)
    (dir && !stp && !rst_done) |=> $stable(func_q)); // R8
  AST_STP_WAKES: assert property (@(posedge clk) disable iff (rst)
    (stp && !func_q[FC_SUSP_N]) |=> func_q[FC_SUSP_N]); // R9
  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(dir) |-> !func_q[FC_RESET]); // R6

endmodule

// File: tb/phy_ctrl_regs_tb.sv
`timescale 1ns/1ps
module phy_ctrl_regs_tb;

  localparam int RC = 6;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;
  logic       stp;
  logic       dir, core_rst, rxcmd_req, suspend_n, term_sel;
  logic [1:0] op_mode, xcvr_sel;
  logic [7:0] intf_reg;

  int errors = 0;
  int checks = 0;
  logic [7:0] mf, mi;

  always #4 clk = ~clk;

  phy_ctrl_regs #(.RST_CYCLES(RC)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .stp(stp), .dir(dir),
    .core_rst(core_rst), .rxcmd_req(rxcmd_req), .suspend_n(suspend_n),
    .op_mode(op_mode), .term_sel(term_sel), .xcvr_sel(xcvr_sel),
    .intf_reg(intf_reg)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] alias_apply(input int off, input logic [7:0] cur, input logic [7:0] d);
    if (off == 1) return cur | d;
    if (off == 2) return cur & ~d;
    return d;
  endfunction

  function automatic logic [7:0] model_read(input logic [5:0] a);
    if (a >= 6'h04 && a <= 6'h06) return mf;
    if (a >= 6'h07 && a <= 6'h09) return mi;
    return 8'h00;
  endfunction

  // Applies one cycle to the model (link side never writes while dir is high here).
  function automatic void model_step(input logic we, input logic [5:0] a, input logic [7:0] d, input logic s);
    logic wk;
    wk = s && !mf[6];
    if (we && a >= 6'h04 && a <= 6'h06) mf = alias_apply(int'(a) - 4, mf, d) & 8'h7F;
    if (we && a >= 6'h07 && a <= 6'h09) mi = alias_apply(int'(a) - 7, mi, d);
    if (wk) mf[6] = 1'b1;
  endfunction

  // Called at a negedge; returns at the following negedge.
  task automatic step(input logic we, input logic [5:0] a, input logic [7:0] d, input logic s);
    reg_we = we; reg_addr = a; reg_wdata = d; stp = s;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; stp = 1'b0;
  endtask

  task automatic check_outputs(input string req);
    check({req, " suspend_n"}, {7'd0, suspend_n}, {7'd0, mf[6]});
    check({req, " fields"}, {3'd0, op_mode, term_sel, xcvr_sel}, {3'd0, mf[4:0]});
    check({req, " intf_reg"}, intf_reg, mi);
  endtask

  task automatic rd_check(input string req, input logic [5:0] a, input logic [7:0] exp);
    step(1'b0, a, 8'h00, 1'b0);
    check(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; stp = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mf = 8'h41; mi = 8'h00;

    // R1 reset state
    check("R1 dir", {7'd0, dir}, 8'h00);
    check("R1 core_rst", {7'd0, core_rst}, 8'h00);
    check("R1 rxcmd_req", {7'd0, rxcmd_req}, 8'h00);
    check_outputs("R1");
    rd_check("R1 func read", 6'h04, 8'h41);
    rd_check("R1 intf read", 6'h07, 8'h00);

    // R2 and R5: function control aliases, reserved bit 7
    step(1'b1, 6'h04, 8'h9A, 1'b0); mf = 8'h1A;
    rd_check("R5 reserved bit ignored on write", 6'h05, 8'h1A);
    step(1'b1, 6'h05, 8'hC4, 1'b0); mf = 8'h5E;
    rd_check("R2 set alias", 6'h06, 8'h5E);
    step(1'b1, 6'h06, 8'h0A, 1'b0); mf = 8'h54;
    rd_check("R2 clear alias", 6'h04, 8'h54);
    check_outputs("R11");

    // R3 interface control aliases
    step(1'b1, 6'h07, 8'hA5, 1'b0); mi = 8'hA5;
    rd_check("R3 write alias", 6'h08, 8'hA5);
    step(1'b1, 6'h08, 8'h18, 1'b0); mi = 8'hBD;
    rd_check("R3 set alias", 6'h09, 8'hBD);
    step(1'b1, 6'h09, 8'h81, 1'b0); mi = 8'h3C;
    rd_check("R3 clear alias", 6'h07, 8'h3C);

    // R4 unmapped addresses
    step(1'b1, 6'h0A, 8'hFF, 1'b0);
    check("R4 unmapped read", reg_rdata, 8'h00);
    step(1'b1, 6'h03, 8'hFF, 1'b0);
    check("R4 unmapped read low", reg_rdata, 8'h00);
    check_outputs("R4 unmapped write no effect");

    // R9 suspend and wake
    step(1'b1, 6'h06, 8'h40, 1'b0); mf = 8'h14;
    check("R9 suspended", {7'd0, suspend_n}, 8'h00);
    step(1'b0, 6'h00, 8'h00, 1'b1); mf = 8'h54;
    check("R9 stp wake", {7'd0, suspend_n}, 8'h01);
    step(1'b0, 6'h00, 8'h00, 1'b1);
    rd_check("R9 stp while powered", 6'h04, 8'h54);

    // R10 wake and write in the same cycle
    step(1'b1, 6'h06, 8'h40, 1'b0); mf = 8'h14;
    step(1'b1, 6'h04, 8'h03, 1'b1); mf = 8'h43;
    rd_check("R10 wake with write", 6'h04, 8'h43);
    check_outputs("R10");

    // R6, R7, R8 transceiver reset sequence
    step(1'b1, 6'h05, 8'h20, 1'b0); mf = 8'h63;
    check("R6 dir not before one cycle", {7'd0, dir}, 8'h00);
    for (int k = 0; k < RC; k++) begin
      reg_we = (k == 2) || (k == 3);
      reg_addr = (k == 2) ? 6'h07 : 6'h04;
      reg_wdata = (k == 2) ? 8'hFF : 8'h00;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
      check("R6 dir during reset", {7'd0, dir}, 8'h01);
      check("R6 core_rst during reset", {7'd0, core_rst}, 8'h01);
    end
    @(posedge clk);
    @(negedge clk);
    mf = 8'h43;
    check("R6 dir released", {7'd0, dir}, 8'h00);
    check("R6 core_rst released", {7'd0, core_rst}, 8'h00);
    check("R7 no request with dir fall", {7'd0, rxcmd_req}, 8'h00);
    step(1'b0, 6'h04, 8'h00, 1'b0);
    check("R6 bit5 self cleared", reg_rdata, 8'h43);
    check("R7 request one cycle after", {7'd0, rxcmd_req}, 8'h01);
    step(1'b0, 6'h07, 8'h00, 1'b0);
    check("R7 request single cycle", {7'd0, rxcmd_req}, 8'h00);
    check("R8 intf write ignored", reg_rdata, 8'h3C);
    check_outputs("R8 func write ignored");

    // Random phase (bit 5 kept clear so dir stays low)
    for (int n = 0; n < 400; n++) begin
      logic       we, s;
      logic [5:0] a;
      logic [7:0] d, exp_rd;
      we = $urandom_range(1, 0) == 1;
      s  = $urandom_range(3, 0) == 0;
      a  = 6'($urandom_range(11, 2));
      d  = 8'($urandom);
      if (a == 6'h04 || a == 6'h05) d[5] = 1'b0;
      exp_rd = model_read(a);
      step(we, a, d, s);
      model_step(we, a, d, s);
      check("R2 R3 R4 random read", reg_rdata, exp_rd);
      check_outputs("R9 R10 R11 random");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule